// File: doc/BRIEF.md
# External Multiplexed Bus Cycle Sequencer

This block turns single requests from a core into external bus cycles. The bus shares one byte-wide port between the low address and data. Every cycle begins with an address latch enable pulse. During that pulse the low address byte goes out on the shared port, while the high address byte sits on a separate output for the whole cycle. After that, one of three active-low strobes runs its own fixed pattern:

- a program-store enable for code fetches;
- a read strobe for data reads;
- a write strobe for data writes.

All timing is counted in whole clocks of the oscillator that drives the block.

The core offers a request with a kind code, a 16-bit address and, for writes, a data byte. The block takes the request when it is idle, or in the final clock of the running cycle. It raises `busy` and plays out the strobe pattern. For fetches and reads it latches the byte present on the port input in the last clock the strobe is low. It returns that byte on `rdata` together with a one-clock `done` pulse. Because a new request can be taken in the `done` clock, address latch enable rises again one clock after a strobe returns high, so back-to-back cycles leave no gap.

Top module: `xbus_seq`

## Requirements
- R1: In the first clock after a request is taken, `ale` goes high. It stays high for exactly 2 clocks, then stays low until the next cycle starts.
- R2: `ad_oe` is high and `ad_out` carries the low address byte from 1 clock before `ale` falls through the first clock after it falls. On a fetch the port is released in the clock `psen_n` falls. On a read it is released in the clock `rd_n` falls. In between, the low address stays on the port.
- R3: In a fetch, `psen_n` falls 1 clock after `ale` falls and stays low for exactly 3 clocks.
- R4: In a fetch, the byte on `ad_in` during the last clock `psen_n` is low appears on `rdata` in the clock `psen_n` returns high. `done` is high in that same clock.
- R5: In a read, `rd_n` falls 3 clocks after `ale` falls and stays low for exactly 6 clocks. `ad_oe` is low from the clock `rd_n` falls.
- R6: In a read, the byte on `ad_in` during the last clock `rd_n` is low appears on `rdata` in the clock `rd_n` rises. `done` is high in that same clock.
- R7: In a write, `wr_n` falls 3 clocks after `ale` falls and stays low for exactly 6 clocks. The write byte is driven with `ad_oe` high from 1 clock before `wr_n` falls through the clock `wr_n` rises. Before that, the low address stays on the port.
- R8: `done` is a single-clock pulse in the clock the strobe returns high. If a request is present in that clock, `ale` rises in the very next clock.
- R9: `a_hi` holds the high address byte of the current request from the first `ale` clock through the `done` clock.
- R10: Kind codes are 2'b00 fetch, 2'b01 read and 2'b10 write. `busy` is high from the clock after acceptance through the `done` clock. A request is ignored if it arrives while `busy` is high outside the `done` clock, or if it carries kind 2'b11.
- R11: While no cycle runs, and after reset, `ale` and `ad_oe` are low, all strobes are high and `done` is low. At most one strobe is low at any time, and none is low while `ale` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all timing counts in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 none |
| req_addr | input | 16 | Full address of the request |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte captured by the last fetch or read |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program-store enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_oe | output | 1 | Output enable of the shared port |
| ad_out | output | 8 | Value driven on the shared port |
| ad_in | input | 8 | Value read from the shared port |
| a_hi | output | 8 | High address byte |

## Verification
In a chained cycle, the `done` pulse and the acceptance of the next request fall in the same clock. The bench provokes this by presenting each following request exactly in the clock where `busy` and `done` are both high. It then requires `ale` to be high at the very next sample, while the finished cycle's byte is still correct on `rdata`. A second collision is a request that arrives in the middle of a running cycle. The bench judges it through the unchanged strobe trace and the unchanged `a_hi`, and through the absence of any extra cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    XK_FETCH = 2'b00,
    XK_READ  = 2'b01,
    XK_WRITE = 2'b10,
    XK_NONE  = 2'b11
  } xkind_e;

  typedef struct packed {
    logic ale;
    logic psen_n;
    logic rd_n;
    logic wr_n;
    logic oe;
    logic sel_wdata;
    logic done;
  } xpins_t;

  // clock (counted from the first ALE clock) where program-store enable falls
  function automatic int unsigned psen_fall_ph(int unsigned ale_clks);
    return ale_clks + 1;
  endfunction

  // clock where the read or write strobe falls
  function automatic int unsigned stb_fall_ph(int unsigned ale_clks);
    return ale_clks + 3;
  endfunction

  // final clock of a fetch: program-store enable is high again
  function automatic int unsigned fetch_last_ph(int unsigned ale_clks, int unsigned ps_clks);
    return psen_fall_ph(ale_clks) + ps_clks;
  endfunction

  // final clock of a read or write: strobe is high again
  function automatic int unsigned rw_last_ph(int unsigned ale_clks, int unsigned stb_clks);
    return stb_fall_ph(ale_clks) + stb_clks;
  endfunction

  function automatic int unsigned phase_bits(int unsigned ale_clks, int unsigned ps_clks,
                                             int unsigned stb_clks);
    int unsigned mx;
    mx = fetch_last_ph(ale_clks, ps_clks);
    if (rw_last_ph(ale_clks, stb_clks) > mx) mx = rw_last_ph(ale_clks, stb_clks);
    return $clog2(mx + 1);
  endfunction

endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr
  import xbus_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 8,
  parameter int unsigned ALE_CLKS = 2,
  parameter int unsigned PS_CLKS  = 3,
  parameter int unsigned STB_CLKS = 6,
  parameter int unsigned PH_W     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      req_kind,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            nxt_active,
  output xkind_e          nxt_kind,
  output logic [PH_W-1:0] nxt_ph,
  output logic [AW-1:0]   nxt_addr,
  output logic [DW-1:0]   nxt_wdata,
  output logic            accept,
  output logic            finish,
  output logic            capture_now
);

  localparam int unsigned LAST_F  = fetch_last_ph(ALE_CLKS, PS_CLKS);
  localparam int unsigned LAST_RW = rw_last_ph(ALE_CLKS, STB_CLKS);

  logic            cur_active;
  xkind_e          cur_kind;
  logic [PH_W-1:0] cur_ph;
  logic [AW-1:0]   cur_addr;
  logic [DW-1:0]   cur_wdata;
  int unsigned     cur_last;
  int unsigned     cur_p;
  xkind_e          in_kind;

  assign in_kind  = xkind_e'(req_kind);
  assign cur_p    = 32'(cur_ph);
  assign cur_last = (cur_kind == XK_FETCH) ? LAST_F : LAST_RW;

  assign finish      = cur_active && (cur_p == cur_last);
  assign accept      = req_valid && (in_kind != XK_NONE) && (!cur_active || finish);
  assign capture_now = cur_active && (cur_kind != XK_WRITE) && (cur_p + 1 == cur_last);

  always_comb begin
    nxt_active = cur_active;
    nxt_kind   = cur_kind;
    nxt_ph     = cur_ph;
    nxt_addr   = cur_addr;
    nxt_wdata  = cur_wdata;
    if (accept) begin
      nxt_active = 1'b1;
      nxt_kind   = in_kind;
      nxt_ph     = '0;
      nxt_addr   = req_addr;
      nxt_wdata  = req_wdata;
    end else if (finish) begin
      nxt_active = 1'b0;
      nxt_ph     = '0;
    end else if (cur_active) begin
      nxt_ph = cur_ph + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_active <= 1'b0;
      cur_kind   <= XK_FETCH;
      cur_ph     <= '0;
      cur_addr   <= '0;
      cur_wdata  <= '0;
    end else begin
      cur_active <= nxt_active;
      cur_kind   <= nxt_kind;
      cur_ph     <= nxt_ph;
      cur_addr   <= nxt_addr;
      cur_wdata  <= nxt_wdata;
    end
  end

endmodule

// File: rtl/xbus_pin_decode.sv
module xbus_pin_decode
  import xbus_pkg::*;
#(
  parameter int unsigned ALE_CLKS = 2,
  parameter int unsigned PS_CLKS  = 3,
  parameter int unsigned STB_CLKS = 6,
  parameter int unsigned PH_W     = 4
) (
  input  logic            active,
  input  xkind_e          kind,
  input  logic [PH_W-1:0] ph,
  output xpins_t          pins
);

  localparam int unsigned A_ON    = ALE_CLKS - 1;
  localparam int unsigned PS_FALL = psen_fall_ph(ALE_CLKS);
  localparam int unsigned ST_FALL = stb_fall_ph(ALE_CLKS);
  localparam int unsigned LAST_F  = fetch_last_ph(ALE_CLKS, PS_CLKS);
  localparam int unsigned LAST_RW = rw_last_ph(ALE_CLKS, STB_CLKS);

  int unsigned p;
  assign p = 32'(ph);

  always_comb begin
    pins = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
             oe: 1'b0, sel_wdata: 1'b0, done: 1'b0};
    if (active) begin
      pins.ale = (p < ALE_CLKS);
      unique case (kind)
        XK_FETCH: begin
          pins.psen_n = !(p >= PS_FALL && p < LAST_F);
          pins.oe     = (p >= A_ON && p < PS_FALL);
          pins.done   = (p == LAST_F);
        end
        XK_READ: begin
          pins.rd_n = !(p >= ST_FALL && p < LAST_RW);
          pins.oe   = (p >= A_ON && p < ST_FALL);
          pins.done = (p == LAST_RW);
        end
        XK_WRITE: begin
          pins.wr_n      = !(p >= ST_FALL && p < LAST_RW);
          pins.oe        = (p >= A_ON);
          pins.sel_wdata = (p + 1 >= ST_FALL);
          pins.done      = (p == LAST_RW);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/xbus_capture.sv
module xbus_capture #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture_now,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rdata <= '0;
    else if (capture_now) rdata <= ad_in;
  end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned AHW      = 8,
  parameter int unsigned ALE_CLKS = 2,
  parameter int unsigned PS_CLKS  = 3,
  parameter int unsigned STB_CLKS = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [1:0]     req_kind,
  input  logic [DW+AHW-1:0] req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           busy,
  output logic           done,
  output logic [DW-1:0]  rdata,
  output logic           ale,
  output logic           psen_n,
  output logic           rd_n,
  output logic           wr_n,
  output logic           ad_oe,
  output logic [DW-1:0]  ad_out,
  input  logic [DW-1:0]  ad_in,
  output logic [AHW-1:0] a_hi
);

  localparam int unsigned AW   = DW + AHW;
  localparam int unsigned PH_W = phase_bits(ALE_CLKS, PS_CLKS, STB_CLKS);

  logic            nxt_active;
  xkind_e          nxt_kind;
  logic [PH_W-1:0] nxt_ph;
  logic [AW-1:0]   nxt_addr;
  logic [DW-1:0]   nxt_wdata;
  xpins_t          nxt_pins;
  logic            accept;
  logic            finish;
  logic            capture_now;

  xbus_phase_ctr #(
    .AW(AW), .DW(DW), .ALE_CLKS(ALE_CLKS), .PS_CLKS(PS_CLKS),
    .STB_CLKS(STB_CLKS), .PH_W(PH_W)
  ) ctr_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .nxt_active(nxt_active),
    .nxt_kind(nxt_kind), .nxt_ph(nxt_ph), .nxt_addr(nxt_addr),
    .nxt_wdata(nxt_wdata), .accept(accept), .finish(finish),
    .capture_now(capture_now)
  );

  xbus_pin_decode #(
    .ALE_CLKS(ALE_CLKS), .PS_CLKS(PS_CLKS), .STB_CLKS(STB_CLKS), .PH_W(PH_W)
  ) dec_i (
    .active(nxt_active), .kind(nxt_kind), .ph(nxt_ph), .pins(nxt_pins)
  );

  xbus_capture #(.DW(DW)) cap_i (
    .clk(clk), .rst_n(rst_n), .capture_now(capture_now), .ad_in(ad_in), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale    <= 1'b0;
      psen_n <= 1'b1;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      ad_oe  <= 1'b0;
      ad_out <= '0;
      a_hi   <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      ale    <= nxt_pins.ale;
      psen_n <= nxt_pins.psen_n;
      rd_n   <= nxt_pins.rd_n;
      wr_n   <= nxt_pins.wr_n;
      ad_oe  <= nxt_pins.oe;
      ad_out <= !nxt_pins.oe ? '0 : (nxt_pins.sel_wdata ? nxt_wdata : nxt_addr[DW-1:0]);
      a_hi   <= nxt_addr[AW-1:DW];
      busy   <= nxt_active;
      done   <= nxt_pins.done;
    end
  end

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
  parameter int unsigned ALE_CLKS = 2,
  parameter int unsigned PS_CLKS  = 3,
  parameter int unsigned STB_CLKS = 6
) (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic busy,
  input logic done,
  input logic accept,
  input logic finish,
  input logic capture_now
);

  logic [7:0] ale_run, ps_run, rd_run, wr_run;

  function automatic logic [7:0] bump(logic [7:0] c, logic on);
    if (!on) return 8'd0;
    return (c == 8'hFF) ? c : c + 8'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_run <= '0; ps_run <= '0; rd_run <= '0; wr_run <= '0;
    end else begin
      ale_run <= bump(ale_run, ale);
      ps_run  <= bump(ps_run, !psen_n);
      rd_run  <= bump(rd_run, !rd_n);
      wr_run  <= bump(wr_run, !wr_n);
    end
  end

  AST_ALE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && $past(ale)) |-> (32'(ale_run) == ALE_CLKS)); // R1
  AST_ACCEPT_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ale); // R1
  AST_PSEN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (psen_n && !$past(psen_n)) |-> (32'(ps_run) == PS_CLKS)); // R3
  AST_RD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && !$past(rd_n)) |-> (32'(rd_run) == STB_CLKS)); // R5
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> !ad_oe); // R5
  AST_CAPTURE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    capture_now |=> done); // R6
  AST_WR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n && !$past(wr_n)) |-> (32'(wr_run) == STB_CLKS)); // R7
  AST_WR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    done == finish); // R8
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R10
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1); // R11
  AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n)); // R11

endmodule

bind xbus_seq xbus_seq_chk #(
  .ALE_CLKS(ALE_CLKS), .PS_CLKS(PS_CLKS), .STB_CLKS(STB_CLKS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
  .ad_oe(ad_oe), .busy(busy), .done(done), .accept(accept), .finish(finish),
  .capture_now(capture_now)
);

// File: tb/xbus_seq_tb_top.sv
module xbus_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        busy, done, ale, psen_n, rd_n, wr_n, ad_oe;
  logic [7:0]  rdata, ad_out, ad_in, a_hi;

  always #10 clk = ~clk;

  xbus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_oe(ad_oe), .ad_out(ad_out), .ad_in(ad_in), .a_hi(a_hi)
  );

  typedef struct {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  exp_rd;
    bit          b2b;
  } item_t;

  typedef struct packed {
    logic       ale, psen_n, rd_n, wr_n, oe;
    logic [7:0] ad;
    logic       done;
  } mpins_t;

  item_t q[$];
  item_t cur;
  bit    cur_v = 0;
  int    ph = 0;
  int    nchk = 0, nfail = 0;
  int    ncnt = 0, last_done = -100;
  bit    ended = 0;
  logic [15:0] lat = '0;
  logic        prev_ale = 1'b0;

  // external memory model: content derived from the latched address
  function automatic logic [7:0] code_byte(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  function automatic logic [7:0] data_byte(logic [15:0] a);
    return a[7:0] + a[15:8] + 8'h11;
  endfunction

  assign ad_in = !psen_n ? code_byte(lat) : (!rd_n ? data_byte(lat) : 8'hEE);

  // expected pin pattern per kind and clock index from the first ALE clock
  function automatic mpins_t model(item_t it, int p);
    mpins_t m;
    m = '{ale: (p < 2), psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, oe: 1'b0, ad: 8'h00, done: 1'b0};
    case (it.kind)
      2'b00: begin
        m.psen_n = !(p >= 3 && p <= 5);
        m.oe     = (p == 1 || p == 2);
        m.done   = (p == 6);
        if (m.oe) m.ad = it.addr[7:0];
      end
      2'b01: begin
        m.rd_n = !(p >= 5 && p <= 10);
        m.oe   = (p >= 1 && p <= 4);
        m.done = (p == 11);
        if (m.oe) m.ad = it.addr[7:0];
      end
      default: begin
        m.wr_n = !(p >= 5 && p <= 10);
        m.oe   = (p >= 1);
        m.done = (p == 11);
        if (p >= 4) m.ad = it.wdata;
        else if (m.oe) m.ad = it.addr[7:0];
      end
    endcase
    return m;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
    end
  endtask

  // address latch seen by the memory model
  always @(negedge clk) begin
    if (prev_ale && !ale) lat = {a_hi, ad_out};
    prev_ale = ale;
  end

  // monitor: pops expected cycles and compares the trace clock by clock
  always @(negedge clk) begin
    if (rst_n) begin
      mpins_t m;
      ncnt++;
      if (!cur_v && q.size() > 0 && ale) begin
        cur = q.pop_front();
        cur_v = 1;
        ph = 0;
        if (cur.b2b) chk("R8 ale gap after done", 16'(ncnt - last_done), 16'd1);
      end
      if (cur_v) begin
        m = model(cur, ph);
        chk("R1 ale", {15'd0, ale}, {15'd0, m.ale});
        chk("R3 psen_n", {15'd0, psen_n}, {15'd0, m.psen_n});
        chk("R5 rd_n", {15'd0, rd_n}, {15'd0, m.rd_n});
        chk("R7 wr_n", {15'd0, wr_n}, {15'd0, m.wr_n});
        chk("R2 ad_oe", {15'd0, ad_oe}, {15'd0, m.oe});
        if (m.oe) chk((cur.kind == 2'b10 && ph >= 4) ? "R7 write data" : "R2 address",
                      {8'd0, ad_out}, {8'd0, m.ad});
        chk("R9 a_hi", {8'd0, a_hi}, {8'd0, cur.addr[15:8]});
        chk("R10 busy", {15'd0, busy}, 16'd1);
        chk("R8 done", {15'd0, done}, {15'd0, m.done});
        if (m.done) begin
          if (cur.kind == 2'b00) chk("R4 fetch byte", {8'd0, rdata}, {8'd0, cur.exp_rd});
          if (cur.kind == 2'b01) chk("R6 read byte", {8'd0, rdata}, {8'd0, cur.exp_rd});
          last_done = ncnt;
          cur_v = 0;
        end else begin
          ph++;
        end
      end else begin
        chk("R11 idle pins", {11'd0, ale, psen_n, rd_n, wr_n, ad_oe}, 16'b01110);
        chk("R11 idle done", {15'd0, done}, 16'd0);
      end
    end
  end

  // driver: waits for an opening, presents the request, records the expectation
  task automatic issue(logic [1:0] k, logic [15:0] a, logic [7:0] wd);
    item_t it;
    @(negedge clk);
    while (busy && !done) @(negedge clk);
    it.kind   = k;
    it.addr   = a;
    it.wdata  = wd;
    it.exp_rd = (k == 2'b00) ? code_byte(a) : data_byte(a);
    it.b2b    = busy && done;
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
    q.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // a request that must be ignored: no expectation is recorded
  task automatic poke(logic [1:0] k, logic [15:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = 8'hA5;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (q.size() > 0 || cur_v) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b00; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset pins", {11'd0, ale, psen_n, rd_n, wr_n, ad_oe}, 16'b01110);
    chk("R10 reset busy", {14'd0, busy, done}, 16'd0);
    rst_n = 1'b1;

    // single cycles of each kind (R3 R4 R5 R6 R7)
    issue(2'b00, 16'h1234, 8'h00);
    drain();
    issue(2'b01, 16'hABCD, 8'h00);
    drain();
    issue(2'b10, 16'h5678, 8'h9E);
    drain();

    // chained cycles: next request taken in the done clock (R8)
    issue(2'b00, 16'h0F0F, 8'h00);
    issue(2'b01, 16'h8001, 8'h00);
    issue(2'b10, 16'h4321, 8'h5A);
    issue(2'b00, 16'hC0DE, 8'h00);
    issue(2'b01, 16'h7E81, 8'h00);
    drain();

    // request during a running cycle is ignored (R10, R9 via a_hi trace)
    issue(2'b01, 16'h2000, 8'h00);
    poke(2'b10, 16'hFFFF);
    drain();

    // kind 11 while idle is ignored (R10)
    poke(2'b11, 16'h3333);
    repeat (3) begin
      @(negedge clk);
      chk("R10 kind 11 ignored", {14'd0, busy, ale}, 16'd0);
    end

    // address and data extremes
    issue(2'b01, 16'h0000, 8'h00);
    issue(2'b10, 16'hFFFF, 8'hFF);
    issue(2'b10, 16'h0000, 8'h00);
    issue(2'b00, 16'hFFFF, 8'h00);
    drain();

    chk("R10 no stray cycles", 16'(q.size()), 16'd0);
    finish_run();
  end

endmodule